// File: doc/BRIEF.md
# Processor-Side Memory Access Unit

This unit sits between a processor and a word-addressed memory. The processor hands it a command: read or write, an address, and write data when the command is a write. The unit latches the address into an address register and the data into a data register. It then raises a request toward the memory with the address and the operation type.

The memory finishes the operation whenever it is ready and signals this with a completion acknowledge, so its latency may vary from one transfer to the next. On a read, the data register captures the data-in bus in the cycle the acknowledge is seen. On a write, the data register drives the data-out bus with an output enable for the whole transfer. After the acknowledge, the unit drops the request, returns to idle and gives the processor a one-cycle done pulse. The processor may issue a new command whenever the unit is not busy, including in the cycle that carries the done pulse.

Top module: `mem_access_unit`

## Requirements
- R1: While reset is low and in the first cycle after reset, `busy`, `done`, `mem_req` and `mem_data_oe` are all 0.
- R2: A command presented with `cmd_valid`=1 while `busy`=0 is accepted at that clock edge. From the next cycle on, `busy`=1 and `mem_req`=1, `mem_addr` equals the command address, and `mem_rw` equals `cmd_write` (1 = write, 0 = read).
- R3: `cmd_valid` is ignored while `busy`=1. Address, operation and the number of completed transfers are unchanged by it.
- R4: `mem_data_oe` is 1 exactly while a write request is outstanding. During that time `mem_data_out` carries the command's write data and stays stable. Outside a write transfer the bus is released (`mem_data_oe`=0).
- R5: On a read, `rdata` holds the value that `mem_data_in` had in the cycle in which `mem_mfc` was seen, starting from the done cycle.
- R6: `done` is high for exactly one cycle: the cycle after `mem_mfc` is seen while waiting. In that cycle `busy`=0 and `mem_req`=0.
- R7: `mem_mfc` is honoured only while waiting for completion. A pulse while idle produces no `done` and no `busy`.
- R8: The transfer takes an arbitrary number of cycles. `busy` and `mem_req` stay high until the acknowledge arrives, for any latency from 1 to 8 cycles after the first request cycle.
- R9: A command presented in the cycle in which `done` is high is accepted like any other idle command.
- R10: While `mem_req` is high and no acknowledge is present, `mem_req`, `mem_addr` and `mem_rw` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_wdata | input | DATA_W | Write data of the command |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Contents of the data register |
| mem_req | output | 1 | Request to memory |
| mem_rw | output | 1 | Operation to memory, 1 = write |
| mem_addr | output | ADDR_W | Address bus from the address register |
| mem_data_out | output | DATA_W | Data bus driven on writes |
| mem_data_oe | output | 1 | Drive enable for the data bus |
| mem_data_in | input | DATA_W | Data bus returned on reads |
| mem_mfc | input | 1 | Memory function complete acknowledge |

## Verification
Two events can fall in the same cycle: the done pulse that closes one transfer and the acceptance of the next command. The bench provokes this by issuing each command as soon as `busy` is seen low, which is the done cycle itself. It then checks that the new command reaches the memory with its own address and operation, while the completed read still reports the captured word. A random responder latency of 1 to 8 cycles also makes the shortest case happen, where the acknowledge lands in the first waiting cycle. Corrupted data-in values outside the acknowledge cycle expose any capture made in the wrong cycle.

// File: rtl/mau_pkg.sv
// Shared types for the memory access unit.
// Assumes: nothing beyond standard SystemVerilog.
package mau_pkg;

    // Handshake controller states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REQUEST  = 2'd1,
        ST_WAIT_MFC = 2'd2
    } mau_state_e;

endpackage

// File: rtl/mau_addr_reg.sv
// Address register plus the latched operation bit; loads on command acceptance.
// Assumes: load is only asserted when the controller is idle.
module mau_addr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              wr_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q
);

    // Capture address and operation when a command is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
        end else if (load) begin
            addr_q <= addr_d;
            wr_q   <= wr_d;
        end
    end

endmodule

// File: rtl/mau_data_reg.sv
// Data register: loads write data at acceptance, or read data at completion.
// Assumes: load_cmd and capture are never high in the same cycle.
module mau_data_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cmd,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              capture,
    input  logic              op_wr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_q
);

    // Write data at acceptance; read data from the bus on completion of a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_cmd && cmd_wr) begin
            data_q <= cmd_data;
        end else if (capture && !op_wr) begin
            data_q <= bus_in;
        end
    end

endmodule

// File: rtl/mau_ctrl_fsm.sv
// Handshake controller: IDLE -> REQUEST -> WAIT_MFC -> IDLE with a done pulse.
// Assumes: the acknowledge is a level sampled only in WAIT_MFC.
module mau_ctrl_fsm
    import mau_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic mfc,
    output logic accept,
    output logic capture,
    output logic busy,
    output logic req,
    output logic done
);

    mau_state_e state_q, state_d;
    logic       done_q;

    // Decode strobes from the current state
    always_comb begin
        accept  = (state_q == ST_IDLE) && cmd_valid;
        capture = (state_q == ST_WAIT_MFC) && mfc;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = ST_REQUEST;
            ST_REQUEST:  state_d = ST_WAIT_MFC;
            ST_WAIT_MFC: if (mfc) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State and done-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= capture;
        end
    end

    // Status toward processor and memory
    always_comb begin
        busy = (state_q != ST_IDLE);
        req  = (state_q == ST_REQUEST) || (state_q == ST_WAIT_MFC);
        done = done_q;
    end

endmodule

// File: rtl/mem_access_unit.sv
// Top of the processor-side memory access unit: address register, data
// register and handshake controller.
// Assumes: memory returns exactly one acknowledge per request.
module mem_access_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_req,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data_out,
    output logic              mem_data_oe,
    input  logic [DATA_W-1:0] mem_data_in,
    input  logic              mem_mfc
);

    logic              accept;
    logic              capture;
    logic [DATA_W-1:0] mdr_q;

    mau_ctrl_fsm u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .mfc       (mem_mfc),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .req       (mem_req),
        .done      (done)
    );

    mau_addr_reg #(.ADDR_W(ADDR_W)) u_mar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .addr_d (cmd_addr),
        .wr_d   (cmd_write),
        .addr_q (mem_addr),
        .wr_q   (mem_rw)
    );

    mau_data_reg #(.DATA_W(DATA_W)) u_mdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cmd (accept),
        .cmd_wr   (cmd_write),
        .cmd_data (cmd_wdata),
        .capture  (capture),
        .op_wr    (mem_rw),
        .bus_in   (mem_data_in),
        .data_q   (mdr_q)
    );

    // Bus drive: data register onto the bus only during a write transfer
    always_comb begin
        mem_data_oe  = mem_req && mem_rw;
        mem_data_out = mdr_q;
        rdata        = mdr_q;
    end

endmodule

// File: rtl/mau_checker.sv
// Protocol checker for mem_access_unit, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module mau_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              mem_req,
    input logic              mem_rw,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data_out,
    input logic              mem_data_oe,
    input logic [DATA_W-1:0] mem_data_in,
    input logic              mem_mfc
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> (busy && mem_req));

    assert_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_data_oe);

    assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_data_oe && !mem_mfc) |=> (mem_data_oe && $stable(mem_data_out)));

    assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mem_rw) |-> (rdata == $past(mem_data_in)));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_stray_mfc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mem_mfc && !cmd_valid) |=> (!done && !busy));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_mfc) |=> (mem_req && $stable(mem_addr) && $stable(mem_rw)));

endmodule

bind mem_access_unit mau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .done         (done),
    .rdata        (rdata),
    .mem_req      (mem_req),
    .mem_rw       (mem_rw),
    .mem_addr     (mem_addr),
    .mem_data_out (mem_data_out),
    .mem_data_oe  (mem_data_oe),
    .mem_data_in  (mem_data_in),
    .mem_mfc      (mem_mfc)
);

// File: tb/tb_mem_access_unit.sv
// Scoreboard bench: driver pushes expected transfers, responder models a
// variable-latency memory, monitor pops and compares on each done pulse.
module tb_mem_access_unit;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, done, mem_req, mem_rw, mem_data_oe;
    logic [DW-1:0] rdata, mem_data_out;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data_in = '0;
    logic          resp_mfc = 1'b0;
    logic          force_mfc = 1'b0;
    logic          mem_mfc;

    assign mem_mfc = resp_mfc | force_mfc;

    int checks = 0;
    int errors = 0;
    int b2b_seen = 0;

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    item_t         exp_q[$];
    logic [DW-1:0] ref_mem  [int];
    logic [DW-1:0] resp_mem [int];
    logic [AW-1:0] seen_addr;
    logic          seen_wr;

    always #2.5 clk = ~clk;

    mem_access_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rdata(rdata), .mem_req(mem_req), .mem_rw(mem_rw), .mem_addr(mem_addr),
        .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe),
        .mem_data_in(mem_data_in), .mem_mfc(mem_mfc)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: wait for idle, push expectation, present command for one cycle
    task automatic issue(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] data);
        item_t it;
        bit    in_done;
        while (busy) @(negedge clk);
        in_done = done;
        it.wr   = wr;
        it.addr = addr;
        it.data = wr ? data : (ref_mem.exists(int'(addr)) ? ref_mem[int'(addr)] : '0);
        if (wr) ref_mem[int'(addr)] = data;
        exp_q.push_back(it);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy && mem_req, in_done ? "R9" : "R2", {busy, mem_req}, 2'b11);
        check(mem_addr == addr, "R2", mem_addr, addr);
        check(mem_rw == wr, "R2", mem_rw, wr);
        if (in_done) b2b_seen++;
    endtask

    // Present a conflicting command while busy; it must leave no trace (R3)
    task automatic poke_busy(input logic [AW-1:0] addr, input bit wr);
        cmd_valid = 1'b1; cmd_write = ~wr; cmd_addr = ~addr; cmd_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(mem_addr == addr && mem_rw == wr, "R3", {mem_addr, mem_rw}, {addr, wr});
    endtask

    // Responder: acknowledge after 1..8 cycles counted from the first request cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                automatic int lat = int'($urandom_range(1, 8));
                for (int k = 1; k <= lat; k++) begin
                    @(negedge clk);
                    check(mem_req && busy, "R8", {mem_req, busy}, 2'b11);
                    check(mem_data_oe == mem_rw, "R4", mem_data_oe, mem_rw);
                end
                seen_addr = mem_addr;
                seen_wr   = mem_rw;
                if (mem_rw) resp_mem[int'(mem_addr)] = mem_data_out;
                else mem_data_in = resp_mem.exists(int'(mem_addr)) ? resp_mem[int'(mem_addr)] : '0;
                resp_mfc = 1'b1;
                @(negedge clk);
                resp_mfc    = 1'b0;
                mem_data_in = $urandom;
            end
        end
    end

    // Monitor: compare each completion against the scoreboard head
    initial begin
        bit prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done && done) check(1'b0, "R6", 2, 1);
                if (!busy) check(!mem_data_oe, "R4", mem_data_oe, 0);
                if (done) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", 1, 0);
                    end else begin
                        automatic item_t it = exp_q.pop_front();
                        check(!busy && !mem_req, "R6", {busy, mem_req}, 2'b00);
                        check(seen_addr == it.addr && seen_wr == it.wr, "R10",
                              {seen_addr, seen_wr}, {it.addr, it.wr});
                        if (!it.wr) check(rdata == it.data, "R5", rdata, it.data);
                    end
                end
                prev_done = done;
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports the summary
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && !mem_data_oe, "R1",
              {busy, done, mem_req, mem_data_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req && !mem_data_oe, "R1",
              {busy, done, mem_req, mem_data_oe}, 0);

        // Stray acknowledge while idle (R7)
        force_mfc = 1'b1;
        @(negedge clk);
        force_mfc = 1'b0;
        check(!done && !busy, "R7", {done, busy}, 0);
        @(negedge clk);
        check(!done && !busy, "R7", {done, busy}, 0);

        // Fill a small address window, then read it back
        for (int a = 0; a < 8; a++) issue(1'b1, AW'(a * 3), $urandom);
        for (int a = 0; a < 8; a++) issue(1'b0, AW'(a * 3), '0);

        // Commands pushed while busy must be ignored (R3)
        issue(1'b1, AW'(6), 32'hA5A5_0F0F);
        poke_busy(AW'(6), 1'b1);
        issue(1'b0, AW'(6), '0);
        poke_busy(AW'(6), 1'b0);

        // Mixed random traffic, issued as soon as idle
        for (int n = 0; n < 60; n++) begin
            automatic bit wr = ($urandom_range(0, 1) == 1);
            issue(wr, AW'($urandom_range(0, 7) * 3), $urandom);
        end

        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(b2b_seen > 0, "R9", b2b_seen, 1);
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule